// File: doc/BRIEF.md
# Serial-Loaded Double-Buffered DAC Code Bank

This block is the digital front end of an eight-channel, 8-bit converter. A host writes 12-bit command words over a three-wire serial port: a serial clock, a data line and an active-low load strobe. Each word carries a channel address, a range bit and an 8-bit code. A falling edge on the load strobe writes the range bit and the code into the addressed channel's input latch.

Each channel also has an output latch, which drives the analog stage. An active-low, level-sensitive update strobe copies every input latch into its output latch.
- When the update strobe is tied low, each load shows at the output right away.
- When the update strobe is held high, any number of channels can be staged and then released together by one low pulse.

All serial pins are sampled in a faster system clock domain through two-flop synchronizers, and their edges are detected there. The shifter keeps only the last 12 bits it received, so a host may send a word as two padded bytes.

Top module: `dac_cmd_bank`

## Requirements
- R1: While rst_ni is low, every code_o byte and every rng_o bit is 0. Reset also clears every input latch and empties the shift register, so an update pulse after reset still gives all zeros.
- R2: A command word is 12 bits and is sent most significant bit first. In order of arrival, the bits are: channel address bits 2, 1 and 0; the range bit; code bits 7 down to 0.
- R3: A data bit is shifted in on each falling edge of ser_clk_i that occurs while ser_load_ni is high. Serial clock edges that occur while ser_load_ni is low leave the shift register unchanged.
- R4: A falling edge of ser_load_ni writes the shifted code and range bit into the input latch of the channel given by the address bits. Address 0 selects channel 0 (code_o bits 7:0) and address 7 selects channel 7 (code_o bits 63:56). No other channel's input latch changes.
- R5: On every system clock edge at which the synchronized upd_ni is low, every output latch takes its input latch's value. With upd_ni held low, a load therefore reaches code_o and rng_o one cycle after the input latch is written.
- R6: While upd_ni is high, code_o and rng_o hold their values. A later low pulse on upd_ni updates all staged channels together.
- R7: Only the 12 most recent bits count. A 16-bit transfer made of 4 leading padding bits followed by a 12-bit word gives the same result as the 12-bit word alone.
- R8: The range bit is stored per channel and appears on rng_o[channel]: 0 selects the x1 output range and 1 selects x2.
- R9: A second load pulse with no serial clock edges since the previous load writes the same word to the same channel again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock; a bit is taken on its falling edge |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| ser_load_ni | input | 1 | Active-low load strobe; its falling edge writes an input latch |
| upd_ni | input | 1 | Active-low, level-sensitive update strobe |
| code_o | output | 64 | Output codes, 8 bits per channel, channel 0 in the low byte |
| rng_o | output | 8 | Output range flags, one per channel (1 = x2) |

## Verification
The bench builds the block with its default parameters: eight channels, 8-bit codes and two synchronizer stages. This exercises all three address bits, the 12-bit word boundary and the padded 16-bit transfer. A behavioural model delays the sampled pins by the synchronizer depth and is compared with the outputs on every cycle. This covers the two update modes, writes to all eight channels, clock edges seen while the load strobe is low, a repeated load, and a reset issued in the middle of the run.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int unsigned DEF_NUM_CH = 8;
  localparam int unsigned DEF_CODE_W = 8;

  // Serial pins carried together through the synchronizer.
  typedef struct packed {
    logic clk;
    logic dat;
    logic load_n;
    logic upd_n;
  } ser_pins_t;

  localparam ser_pins_t PINS_IDLE = '{clk: 1'b0, dat: 1'b0, load_n: 1'b1, upd_n: 1'b1};
endpackage

// File: rtl/dac_bank_sync.sv
module dac_bank_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prv_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < DEPTH; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < DEPTH; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign lvl_o = stg_q[STAGES-1];
  assign prv_o = stg_q[STAGES];
endmodule

// File: rtl/dac_bank_shift.sv
module dac_bank_shift #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              load_hi_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sr_q <= '0;
    else if (fall_i && load_hi_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};
  end

  assign word_o = sr_q;

  // R3: no shift while load strobe is low
  p_hold_load_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_hi_i |=> $stable(sr_q));
  // R2: newest bit lands in the LSB, older bits move up
  p_shift_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && load_hi_i) |=> (sr_q[0] == $past(bit_i)) &&
                              (sr_q[WORD_W-1:1] == $past(sr_q[WORD_W-2:0])));
endmodule

// File: rtl/dac_bank_chan.sv
module dac_bank_chan #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CODE_W:0]   wdata_i,
  input  logic              upd_lo_i,
  output logic [CODE_W-1:0] code_o,
  output logic              rng_o
);
  logic [CODE_W:0] in_q;
  logic [CODE_W:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   in_q <= '0;
    else if (wr_i) in_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_q <= '0;
    else if (upd_lo_i) out_q <= in_q;
  end

  assign rng_o  = out_q[CODE_W];
  assign code_o = out_q[CODE_W-1:0];

  // R4: input latch changes only when selected
  p_in_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(in_q));
  // R6: outputs frozen while update strobe is high
  p_out_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_lo_i |=> $stable(out_q));
  // R5: outputs follow the input latch while update strobe is low
  p_out_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_lo_i |=> (out_q == $past(in_q)));
endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank
  import dac_bank_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ser_clk_i,
  input  logic                     ser_dat_i,
  input  logic                     ser_load_ni,
  input  logic                     upd_ni,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        rng_o
);
  localparam int unsigned ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned WORD_W = ADDR_W + 1 + CODE_W;
  localparam int unsigned PINS_W = $bits(ser_pins_t);

  ser_pins_t pins_raw, pins_lvl, pins_prv;
  logic [PINS_W-1:0] lvl_bits, prv_bits;

  assign pins_raw = '{clk: ser_clk_i, dat: ser_dat_i, load_n: ser_load_ni, upd_n: upd_ni};

  dac_bank_sync #(
    .W      (PINS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .lvl_o (lvl_bits),
    .prv_o (prv_bits)
  );

  assign pins_lvl = ser_pins_t'(lvl_bits);
  assign pins_prv = ser_pins_t'(prv_bits);

  logic sclk_fall, load_fall, load_hi, upd_lo;
  assign sclk_fall = pins_prv.clk & ~pins_lvl.clk;
  assign load_fall = pins_prv.load_n & ~pins_lvl.load_n;
  assign load_hi   = pins_lvl.load_n;
  assign upd_lo    = ~pins_lvl.upd_n;

  logic [WORD_W-1:0] word;

  dac_bank_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (sclk_fall),
    .load_hi_i(load_hi),
    .bit_i    (pins_lvl.dat),
    .word_o   (word)
  );

  logic [ADDR_W-1:0] addr;
  logic [CODE_W:0]   wdata;
  logic [NUM_CH-1:0] wr_vec;

  assign addr  = word[WORD_W-1 -: ADDR_W];
  assign wdata = word[CODE_W:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_vec[c] = load_fall && (addr == ADDR_W'(c));

    dac_bank_chan #(.CODE_W(CODE_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_vec[c]),
      .wdata_i (wdata),
      .upd_lo_i(upd_lo),
      .code_o  (code_o[c*CODE_W +: CODE_W]),
      .rng_o   (rng_o[c])
    );
  end

  // R4: at most one channel written per cycle
  p_one_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_vec));
  // R6: outputs stay put while the synchronized update strobe is high
  p_top_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_lo |=> ($stable(code_o) && $stable(rng_o)));
endmodule

// File: tb/dac_cmd_bank_bench.sv
module dac_cmd_bank_bench;
  localparam int NCH = 8;
  localparam int CW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_clk = 1'b0, s_dat = 1'b0, s_load_n = 1'b1, s_upd_n = 1'b1;
  logic [NCH*CW-1:0] code;
  logic [NCH-1:0]    rng;

  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  dac_cmd_bank u_dac_cmd_bank (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(s_clk), .ser_dat_i(s_dat),
    .ser_load_ni(s_load_n), .upd_ni(s_upd_n), .code_o(code), .rng_o(rng)
  );

  // Behavioural reference: pins seen two cycles late, edges against the cycle before.
  logic [3:0] hist [3];          // {clk, dat, load_n, upd_n}; [0] newest
  logic [11:0] m_sr;
  logic [8:0]  m_in  [NCH];
  logic [8:0]  m_out [NCH];

  always @(posedge clk) begin
    logic [3:0] cur, prv;
    logic [8:0] n_out [NCH];
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) hist[i] = 4'b0011;
      m_sr = '0;
      for (int i = 0; i < NCH; i++) begin m_in[i] = '0; m_out[i] = '0; end
    end else begin
      cur = hist[1];
      prv = hist[2];
      for (int i = 0; i < NCH; i++) n_out[i] = cur[0] ? m_out[i] : m_in[i];
      if (prv[1] && !cur[1]) m_in[m_sr[11:9]] = m_sr[8:0];
      if (prv[3] && !cur[3] && cur[1]) m_sr = {m_sr[10:0], cur[2]};
      for (int i = 0; i < NCH; i++) m_out[i] = n_out[i];
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = {s_clk, s_dat, s_load_n, s_upd_n};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NCH; i++) begin
        checks++;
        if (code[i*CW +: CW] != m_out[i][7:0] || rng[i] != m_out[i][8]) begin
          failures++;
          $display("FAIL %s model ch%0d: got code=%h rng=%b exp code=%h rng=%b",
                   tag, i, code[i*CW +: CW], rng[i], m_out[i][7:0], m_out[i][8]);
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic shift_bits(logic [15:0] w, int n);
    for (int b = n - 1; b >= 0; b--) begin
      s_dat = w[b];
      s_clk = 1'b1; wait_cyc(3);
      s_clk = 1'b0; wait_cyc(3);
    end
  endtask

  task automatic pulse_load();
    s_load_n = 1'b0; wait_cyc(3);
    s_load_n = 1'b1; wait_cyc(3);
  endtask

  task automatic pulse_upd();
    s_upd_n = 1'b0; wait_cyc(3);
    s_upd_n = 1'b1; wait_cyc(6);
  endtask

  function automatic logic [11:0] mk(int ch, bit r, logic [7:0] c);
    return {3'(ch), r, c};
  endfunction

  initial begin
    wait_cyc(3);
    tag = "R1";
    chk("R1 reset codes", code[31:0], 32'h0);
    chk("R1 reset codes hi", code[63:32], 32'h0);
    chk("R1 reset ranges", 32'(rng), 32'h0);
    @(negedge clk); rst_n = 1'b1; wait_cyc(4);

    // Update held low: load reaches output
    tag = "R5"; s_upd_n = 1'b0; wait_cyc(4);
    shift_bits(16'(mk(2, 1'b1, 8'hA5)), 12); pulse_load(); wait_cyc(4);
    chk("R4 ch2 code", 32'(code[2*CW +: CW]), 32'hA5);
    chk("R8 ch2 range x2", 32'(rng[2]), 32'h1);
    chk("R2 ch1 untouched", 32'(code[1*CW +: CW]), 32'h0);

    // Bit order: address 4, code 01
    tag = "R2";
    shift_bits(16'(mk(4, 1'b0, 8'h01)), 12); pulse_load(); wait_cyc(4);
    chk("R2 ch4 code", 32'(code[4*CW +: CW]), 32'h01);
    chk("R8 ch4 range x1", 32'(rng[4]), 32'h0);

    // Padded 16-bit transfer
    tag = "R7";
    shift_bits({4'hF, mk(7, 1'b0, 8'h5A)}, 16); pulse_load(); wait_cyc(4);
    chk("R7 ch7 padded code", 32'(code[7*CW +: CW]), 32'h5A);

    // Clock edges during load low ignored, then repeat load
    tag = "R3";
    shift_bits(16'(mk(1, 1'b0, 8'h11)), 12);
    s_load_n = 1'b0; wait_cyc(3);
    s_dat = 1'b1;
    for (int k = 0; k < 4; k++) begin
      s_clk = 1'b1; wait_cyc(3); s_clk = 1'b0; wait_cyc(3);
    end
    s_load_n = 1'b1; wait_cyc(3);
    chk("R3 ch1 loaded", 32'(code[1*CW +: CW]), 32'h11);
    tag = "R9";
    pulse_load(); wait_cyc(4);
    chk("R9 ch1 rewritten same", 32'(code[1*CW +: CW]), 32'h11);
    chk("R3 ch0 unchanged", 32'(code[0*CW +: CW]), 32'h0);

    // Staged mode
    tag = "R6"; s_upd_n = 1'b1; wait_cyc(4);
    shift_bits(16'(mk(5, 1'b0, 8'h3C)), 12); pulse_load();
    shift_bits(16'(mk(0, 1'b1, 8'h81)), 12); pulse_load(); wait_cyc(4);
    chk("R6 ch5 held", 32'(code[5*CW +: CW]), 32'h0);
    chk("R6 ch0 held", 32'(code[0*CW +: CW]), 32'h0);
    pulse_upd();
    chk("R6 ch5 released", 32'(code[5*CW +: CW]), 32'h3C);
    chk("R6 ch0 released", 32'(code[0*CW +: CW]), 32'h81);
    chk("R8 ch0 range", 32'(rng[0]), 32'h1);

    // All channels staged then released together
    tag = "R4";
    for (int c = 0; c < NCH; c++) begin
      shift_bits(16'(mk(c, c[0], 8'(c * 17 + 3))), 12); pulse_load();
    end
    chk("R6 ch3 before update", 32'(code[3*CW +: CW]), 32'h0);
    pulse_upd();
    for (int c = 0; c < NCH; c++) begin
      chk("R4 channel code", 32'(code[c*CW +: CW]), 32'(8'(c * 17 + 3)));
      chk("R8 channel range", 32'(rng[c]), 32'(c & 1));
    end

    // Reset mid-run clears input latches too
    tag = "R1";
    @(negedge clk); rst_n = 1'b0; wait_cyc(2);
    chk("R1 mid reset codes", code[31:0] | code[63:32], 32'h0);
    rst_n = 1'b1; wait_cyc(4);
    pulse_upd();
    chk("R1 inputs cleared", code[31:0] | code[63:32], 32'h0);
    chk("R1 ranges cleared", 32'(rng), 32'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule